// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and arbitrates five hardware request lines. The lines use different trigger styles:

- **Urgent line.** Non-maskable. It needs a rising edge and must then stay high until the core acknowledges it.
- **Latched line.** Edge-captured into a pending flag.
- **Two level lines.** Maskable and level-sensitive.
- **General line.** Level-sensitive and gated only by the global enable flag.

The block qualifies each request, applies the per-line masks and the global enable flag, and selects the highest-priority request. It then presents a request strobe, a source code and a 16-bit service address to the core.

The core writes a control byte that updates the masks, clears the latched flag and drives a one-bit serial output. It reads back a status byte holding the sampled serial input, the pending flags, the enable flag and the masks. Separate enable and disable commands set and clear the global flag. An acknowledge input tells the block that the presented source is being serviced. When the general line is acknowledged, the core also supplies the restart opcode it fetched, and the block turns that opcode into a service address.

All request inputs and the serial input pass through one register stage before use. The control write, the enable commands, the acknowledge and the opcode act directly.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Fixed priority, highest first: urgent, latched, level-high, level-low, general. `src_o` codes the presented source as 1, 2, 3, 4 and 5 in that order, and 0 when none is presented. `irq_o` is 1 exactly when `src_o` is not 0.
- R2: `vec_o` is 0024h for source 1, 003Ch for source 2, 0034h for source 3 and 002Ch for source 4. It is 0000h when no source is presented.
- R3: The urgent line is requested only after a low-to-high transition of `trap_i`. The request is cancelled if the line falls before acknowledge, and after acknowledge a new rising edge is needed. Masks and the enable flag do not affect it. It appears on `irq_o` three clock edges after the input rises.
- R4: A rising edge on `edge_req_i` sets a pending flag that stays set after the input falls. The flag is cleared by acknowledging source 2, or by a control write with bit 4 set, whether or not the line is masked.
- R5: `lvl_hi_i`, `lvl_lo_i` and `gen_req_i` are level-sensitive. A level appears on `irq_o` two clock edges after it is applied.
- R6: The enable flag resets to 0. `ien_set_i` sets it and `ien_clr_i` clears it; clear wins if both are asserted. Acknowledging source 2, 3, 4 or 5 clears it, while acknowledging source 1 does not. Sources 2 to 5 are requested only while the flag is 1.
- R7: Control byte bits 2, 1 and 0 are the masks for sources 2, 3 and 4. A mask bit of 1 blocks its source. The masks are loaded only when control bit 3 is 1, and all three reset to 1.
- R8: `ser_out_o` resets to 0. A control write with bit 6 set copies bit 7 to it; a write with bit 6 clear leaves it unchanged.
- R9: `stat_o` holds, from bit 7 down to bit 0: sampled serial input, latched pending flag, level-high input, level-low input, enable flag, mask of source 2, mask of source 3, mask of source 4. A pending bit reads 1 even when its source is masked or disabled.
- R10: While source 5 is presented, `vec_o` is 8 times N when `ack_opcode_i` has the form 11NNN111, and 0000h for any other opcode.
- R11: An acknowledge drives `irq_o` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Urgent non-maskable request line |
| edge_req_i | input | 1 | Edge-captured request line |
| lvl_hi_i | input | 1 | Higher level-sensitive maskable line |
| lvl_lo_i | input | 1 | Lower level-sensitive maskable line |
| gen_req_i | input | 1 | General request line gated by the enable flag |
| ser_in_i | input | 1 | Serial input bit |
| ctrl_wr_i | input | 1 | Control byte write strobe |
| ctrl_data_i | input | 8 | Control byte |
| ien_set_i | input | 1 | Enable command |
| ien_clr_i | input | 1 | Disable command |
| ack_i | input | 1 | Acknowledge of the presented source |
| ack_opcode_i | input | 8 | Opcode fetched while servicing the general line |
| stat_o | output | 8 | Status byte |
| ser_out_o | output | 1 | Serial output latch |
| irq_o | output | 1 | Request strobe to the core |
| src_o | output | 3 | Presented source code |
| vec_o | output | 16 | Service address |

## Verification
Each result has a fixed latency, counted from the clock edge that first samples the stimulus:

| Result | Due |
|---|---|
| Level line on `irq_o` | 2 edges |
| Latched or urgent line on `irq_o` | 3 edges (input stage, flag, output register) |
| Status bits for raw levels and serial input | 1 edge |
| Latched pending bit in `stat_o` | 2 edges |
| Effect of a control write, enable command or acknowledge | 1 edge |
| Opcode-derived address | same cycle |

The bench drives every input on the falling edge. The latency checks sample on the exact falling edge at which a result is first due, and also on the edge just before it, so an early or late output is caught. The wide sweeps wait four edges and then compare against the priority model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int VEC_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NSRC   = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_E75  = 3'd2,
    SRC_L65  = 3'd3,
    SRC_L55  = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_E75  = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_L65  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_L55  = 16'h002C;

  // control byte fields
  localparam int CB_SOUT = 7;
  localparam int CB_SEN  = 6;
  localparam int CB_CLR  = 4;
  localparam int CB_MWE  = 3;

  function automatic logic [VEC_W-1:0] restart_vec(input logic [BYTE_W-1:0] op);
    logic [VEC_W-1:0] v;
    v = '0;
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111)
      v = VEC_W'({op[5:3], 3'b000});
    return v;
  endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import prio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trap_i,
  input  logic edge_i,
  input  logic hi_i,
  input  logic lo_i,
  input  logic gen_i,
  input  logic ser_i,
  input  logic ack_trap_i,
  input  logic ack_edge_i,
  input  logic clr_edge_i,
  output logic trap_req_o,
  output logic edge_pend_o,
  output logic hi_o,
  output logic lo_o,
  output logic gen_o,
  output logic ser_o
);
  localparam int NIN = 6;

  logic [NIN-1:0] raw, smp_q;
  logic trap_d_q, edge_d_q, arm_q, pend_q;
  logic arm_nx, pend_nx, trap_rise, edge_rise;

  assign raw = {ser_i, gen_i, lo_i, hi_i, edge_i, trap_i};

  genvar g;
  generate
    for (g = 0; g < NIN; g++) begin : g_smp
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) smp_q[g] <= 1'b0;
        else        smp_q[g] <= raw[g];
    end
  endgenerate

  assign trap_rise = smp_q[0] & ~trap_d_q;
  assign edge_rise = smp_q[1] & ~edge_d_q;

  always_comb begin
    arm_nx = arm_q;
    if (trap_rise) arm_nx = 1'b1;
    if (!smp_q[0] || ack_trap_i) arm_nx = 1'b0;
    pend_nx = pend_q;
    if (edge_rise) pend_nx = 1'b1;
    if (clr_edge_i || ack_edge_i) pend_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_d_q <= 1'b0;
      edge_d_q <= 1'b0;
      arm_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      trap_d_q <= smp_q[0];
      edge_d_q <= smp_q[1];
      arm_q    <= arm_nx;
      pend_q   <= pend_nx;
    end
  end

  assign trap_req_o  = arm_q & smp_q[0];
  assign edge_pend_o = pend_q;
  assign hi_o        = smp_q[2];
  assign lo_o        = smp_q[3];
  assign gen_o       = smp_q[4];
  assign ser_o       = smp_q[5];

  AST_TRAP_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_q[0] |=> !arm_q); // R3
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_edge_i |=> !pend_q); // R4
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              ack_mask_i,
  output logic              ien_o,
  output logic [2:0]        mask_o,
  output logic              ser_o,
  output logic              clr_edge_o
);
  logic       ien_q, ien_nx, ser_q, ser_nx;
  logic [2:0] mask_q, mask_nx;
  logic       mask_en, ser_en;

  assign mask_en    = wr_i & data_i[CB_MWE];
  assign ser_en     = wr_i & data_i[CB_SEN];
  assign clr_edge_o = wr_i & data_i[CB_CLR];

  always_comb begin
    mask_nx = mask_en ? data_i[2:0] : mask_q;
    ser_nx  = ser_en  ? data_i[CB_SOUT] : ser_q;
    ien_nx  = ien_q;
    if (ien_set_i) ien_nx = 1'b1;
    if (ien_clr_i || ack_mask_i) ien_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 3'b111;
      ser_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      mask_q <= mask_nx;
      ser_q  <= ser_nx;
      ien_q  <= ien_nx;
    end
  end

  assign ien_o  = ien_q;
  assign mask_o = mask_q;
  assign ser_o  = ser_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !data_i[CB_MWE]) |=> $stable(mask_q)); // R7
  AST_ACK_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_mask_i |=> !ien_q); // R6
  AST_SER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && data_i[CB_SEN]) |=> (ser_q == $past(data_i[CB_SOUT]))); // R8
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req_i,
  input  logic              edge_pend_i,
  input  logic              hi_i,
  input  logic              lo_i,
  input  logic              gen_i,
  input  logic              ien_i,
  input  logic [2:0]        mask_i,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] opcode_i,
  output logic              irq_o,
  output src_e              src_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NSRC-1:0] req;
  src_e src_q, src_nx;

  assign req[0] = trap_req_i;
  assign req[1] = edge_pend_i & ~mask_i[2] & ien_i;
  assign req[2] = hi_i        & ~mask_i[1] & ien_i;
  assign req[3] = lo_i        & ~mask_i[0] & ien_i;
  assign req[4] = gen_i       & ien_i;

  always_comb begin
    src_nx = SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) src_nx = src_e'(i + 1);
    if (ack_i) src_nx = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_q <= SRC_NONE;
    else        src_q <= src_nx;

  always_comb begin
    case (src_q)
      SRC_TRAP: vec_o = VEC_TRAP;
      SRC_E75:  vec_o = VEC_E75;
      SRC_L65:  vec_o = VEC_L65;
      SRC_L55:  vec_o = VEC_L55;
      SRC_GEN:  vec_o = restart_vec(opcode_i);
      default:  vec_o = '0;
    endcase
  end

  assign irq_o = (src_q != SRC_NONE);
  assign src_o = src_q;

  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && !ack_i) |=> (src_q == SRC_TRAP)); // R1
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !irq_o); // R11
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_i,
  input  logic        edge_req_i,
  input  logic        lvl_hi_i,
  input  logic        lvl_lo_i,
  input  logic        gen_req_i,
  input  logic        ser_in_i,
  input  logic        ctrl_wr_i,
  input  logic [7:0]  ctrl_data_i,
  input  logic        ien_set_i,
  input  logic        ien_clr_i,
  input  logic        ack_i,
  input  logic [7:0]  ack_opcode_i,
  output logic [7:0]  stat_o,
  output logic        ser_out_o,
  output logic        irq_o,
  output logic [2:0]  src_o,
  output logic [15:0] vec_o
);
  logic trap_req, edge_pend, hi_s, lo_s, gen_s, ser_s;
  logic ien, clr_edge, ack_trap, ack_edge, ack_mask;
  logic [2:0] mask;
  src_e src;

  assign ack_trap = ack_i && (src == SRC_TRAP);
  assign ack_edge = ack_i && (src == SRC_E75);
  assign ack_mask = ack_i && (src != SRC_TRAP) && (src != SRC_NONE);

  irq_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .edge_i(edge_req_i),
    .hi_i(lvl_hi_i), .lo_i(lvl_lo_i), .gen_i(gen_req_i), .ser_i(ser_in_i),
    .ack_trap_i(ack_trap), .ack_edge_i(ack_edge), .clr_edge_i(clr_edge),
    .trap_req_o(trap_req), .edge_pend_o(edge_pend), .hi_o(hi_s),
    .lo_o(lo_s), .gen_o(gen_s), .ser_o(ser_s)
  );

  irq_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr_i), .data_i(ctrl_data_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .ack_mask_i(ack_mask),
    .ien_o(ien), .mask_o(mask), .ser_o(ser_out_o), .clr_edge_o(clr_edge)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .edge_pend_i(edge_pend),
    .hi_i(hi_s), .lo_i(lo_s), .gen_i(gen_s), .ien_i(ien), .mask_i(mask),
    .ack_i(ack_i), .opcode_i(ack_opcode_i), .irq_o(irq_o), .src_o(src),
    .vec_o(vec_o)
  );

  assign src_o  = src;
  assign stat_o = {ser_s, edge_pend, hi_s, lo_s, ien, mask};
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_i = 0, edge_req_i = 0, lvl_hi_i = 0, lvl_lo_i = 0, gen_req_i = 0, ser_in_i = 0;
  logic ctrl_wr_i = 0, ien_set_i = 0, ien_clr_i = 0, ack_i = 0;
  logic [7:0] ctrl_data_i = 0, ack_opcode_i = 8'hFF;
  logic [7:0] stat_o;
  logic ser_out_o, irq_o;
  logic [2:0] src_o;
  logic [15:0] vec_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (.*);

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    ctrl_wr_i = 1; ctrl_data_i = d; tick(1); ctrl_wr_i = 0;
  endtask

  task automatic en(input logic on);
    if (on) ien_set_i = 1; else ien_clr_i = 1;
    tick(1); ien_set_i = 0; ien_clr_i = 0;
  endtask

  task automatic ack();
    ack_i = 1; tick(1); ack_i = 0;
  endtask

  function automatic logic [2:0] exp_src(logic [2:0] m, logic ie, logic [2:0] lv, logic pe);
    if (pe && !m[2] && ie) return 3'd2;
    if (lv[2] && !m[1] && ie) return 3'd3;
    if (lv[1] && !m[0] && ie) return 3'd4;
    if (lv[0] && ie) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_vec(logic [2:0] s, logic [7:0] op);
    case (s)
      3'd1: return 16'h0024;
      3'd2: return 16'h003C;
      3'd3: return 16'h0034;
      3'd4: return 16'h002C;
      3'd5: return (op[7:6] == 2'b11 && op[2:0] == 3'b111) ? {10'd0, op[5:3], 3'd0} : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    tick(2); rst_n = 1; tick(1);
    // reset state
    chk(stat_o, 8'h07, "R7 R6 reset status");
    chk(irq_o, 0, "R1 reset irq");
    chk(src_o, 0, "R1 reset src");
    chk(vec_o, 0, "R2 reset vec");
    chk(ser_out_o, 0, "R8 reset serial");

    // urgent line, ignores masks and enable
    trap_i = 1; tick(2);
    chk(irq_o, 0, "R3 urgent not yet at edge 2");
    tick(1);
    chk(irq_o, 1, "R3 urgent at edge 3");
    chk(src_o, 1, "R3 urgent src");
    chk(vec_o, 16'h0024, "R2 urgent vector");
    trap_i = 0; tick(3);
    chk(irq_o, 0, "R3 falls before ack cancels");
    trap_i = 1; tick(3);
    chk(irq_o, 1, "R3 re-raised");
    ack();
    chk(irq_o, 0, "R11 drop after ack");
    tick(3);
    chk(irq_o, 0, "R3 held level needs new edge");
    trap_i = 0; tick(2); trap_i = 1; tick(3);
    chk(irq_o, 1, "R3 new edge re-arms");
    // priority over latched line
    wr(8'h18); en(1);
    edge_req_i = 1; tick(1); edge_req_i = 0; tick(4);
    chk(src_o, 1, "R1 urgent beats latched");
    ack(); trap_i = 0; tick(4);
    chk(src_o, 2, "R6 urgent ack keeps enable, latched next");
    chk(stat_o[3], 1, "R6 enable kept after urgent ack");
    ack(); tick(1);
    chk(stat_o[6], 0, "R4 ack clears latched flag");
    chk(stat_o[3], 0, "R6 maskable ack clears enable");

    // enable commands
    en(1); chk(stat_o[3], 1, "R6 set");
    en(0); chk(stat_o[3], 0, "R6 clear");
    ien_set_i = 1; ien_clr_i = 1; tick(1); ien_set_i = 0; ien_clr_i = 0;
    chk(stat_o[3], 0, "R6 clear wins");

    // mask write gating
    wr(8'h0F); chk(stat_o[2:0], 3'b111, "R7 masks loaded");
    wr(8'h05); chk(stat_o[2:0], 3'b111, "R7 no load without bit 3");
    wr(8'h0A); chk(stat_o[2:0], 3'b010, "R7 bits 2..0 loaded");

    // masked latched flag visible and cleared by bit 4
    wr(8'h0F); en(1);
    edge_req_i = 1; tick(1); edge_req_i = 0; tick(3);
    chk(stat_o[6], 1, "R9 pending shown while masked");
    chk(irq_o, 0, "R7 masked latched blocked");
    wr(8'h10);
    chk(stat_o[6], 0, "R4 bit 4 clears masked flag");

    // serial
    wr(8'h80); chk(ser_out_o, 0, "R8 no copy without bit 6");
    wr(8'hC0); chk(ser_out_o, 1, "R8 copy 1");
    wr(8'h00); chk(ser_out_o, 1, "R8 hold");
    wr(8'h40); chk(ser_out_o, 0, "R8 copy 0");
    ser_in_i = 1; tick(1);
    chk(stat_o[7], 1, "R9 serial input sampled");
    ser_in_i = 0; tick(1);

    // level latency
    wr(8'h08); en(1);
    lvl_hi_i = 1; tick(1);
    chk(stat_o[5], 1, "R9 level bit after one edge");
    chk(irq_o, 0, "R5 not yet at edge 1");
    tick(1);
    chk(irq_o, 1, "R5 level at edge 2");
    lvl_hi_i = 0; ack(); tick(3);

    // sweep: masks x enable x levels x latched flag
    for (int c = 0; c < 256; c++) begin
      logic [2:0] m, lv, es;
      logic ie, pe;
      m = c[2:0]; ie = c[3]; lv = c[6:4]; pe = c[7];
      lvl_hi_i = 0; lvl_lo_i = 0; gen_req_i = 0;
      wr({3'b000, 2'b11, m});
      en(ie);
      if (pe) begin edge_req_i = 1; tick(1); edge_req_i = 0; end
      lvl_hi_i = lv[2]; lvl_lo_i = lv[1]; gen_req_i = lv[0];
      tick(4);
      es = exp_src(m, ie, lv, pe);
      chk(src_o, es, "R1 sweep src");
      chk(irq_o, es != 0, "R1 sweep irq");
      chk(vec_o, exp_vec(es, ack_opcode_i), "R2 sweep vec");
      chk(stat_o[6:0], {pe, lv[2], lv[1], ie, m}, "R9 sweep status");
      if (es != 0) begin
        ack();
        chk(irq_o, 0, "R11 sweep ack drop");
        chk(stat_o[3], 0, "R6 sweep ack disables");
        if (es == 2) chk(stat_o[6], 0, "R4 sweep ack clears flag");
      end
    end
    lvl_hi_i = 0; lvl_lo_i = 0; gen_req_i = 0;

    // general line opcode sweep
    wr(8'h18); en(1); gen_req_i = 1; tick(3);
    for (int op = 0; op < 256; op++) begin
      ack_opcode_i = op[7:0]; #1;
      chk(vec_o, exp_vec(3'd5, op[7:0]), "R10 restart vector");
      tick(1);
    end
    gen_req_i = 0;

    done = 1;
    finish_run();
  end
endmodule